// File: doc/BRIEF.md
# 10BASE-T Link Integrity Monitor

This block decides whether a 10BASE-T twisted-pair link is usable. It watches a receive path that has already been decoded and qualified. That path supplies a one-cycle strobe for each normal link pulse and a level that is high while a packet is being received. From these it keeps a link-good state. The link-good state gates the transmit data path. When the link is lost, the block issues a one-cycle restart request to an external auto-negotiation controller, but only if auto-negotiation is enabled.

A configuration bit bypasses the integrity test. While that bit is set, transmission is allowed whatever the link state. While the port is in 10BASE-T mode, the block also emits its own periodic link-pulse strobe. That strobe runs whatever the link state or the bypass setting. All timing comes from a millisecond tick supplied by the chip. The loss timeout and the pulse period are parameters counted in ticks.

Top module: `link_integrity_mon`

## Requirements
- R1: After a synchronous active-low reset, link_good, restart_autoneg and link_pulse_out are 0, and tx_enable equals test_bypass.
- R2: While link_good is 0 and mode_10bt is 1, a cycle with link_pulse_in high sets link_good to 1 in the next cycle.
- R3: Receive activity alone (rx_active high with no link pulse) never sets link_good while it is 0.
- R4: While link_good is 1, every cycle with link_pulse_in or rx_active high restarts the loss count. link_good falls to 0 at the clock edge that takes the LOSS_MS-th consecutive ms_tick with no such event.
- R5: A link pulse or receive activity in the same cycle as the ms_tick that would otherwise expire the loss count keeps link_good at 1 and restarts the count.
- R6: When link loss clears link_good, restart_autoneg is 1 for exactly the first cycle in which link_good reads 0, provided an_enable was 1 in the expiring cycle. Otherwise restart_autoneg stays 0.
- R7: tx_enable is 1 exactly when link_good is 1 or test_bypass is 1.
- R8: While mode_10bt is 1, link_pulse_out is high for one cycle, in the cycle after every PULSE_PERIOD_MS-th ms_tick. The count starts when mode_10bt becomes 1 or when reset is released.
- R9: The link-pulse emission is unaffected by link_good, test_bypass and an_enable. While mode_10bt is 0, no pulse is emitted and the tick count is held at zero.
- R10: While mode_10bt is 0, link_good is 0 from the next cycle on, link pulses are ignored, and no restart request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle strobe each millisecond |
| mode_10bt | input | 1 | Port is operating in 10BASE-T mode |
| an_enable | input | 1 | Auto-negotiation enabled |
| test_bypass | input | 1 | Integrity-test disable; 1 forces transmit enable |
| link_pulse_in | input | 1 | Qualified received link-pulse strobe |
| rx_active | input | 1 | Receive packet activity |
| link_pulse_out | output | 1 | Periodic transmitted link-pulse strobe |
| link_good | output | 1 | Link integrity established |
| tx_enable | output | 1 | Transmit data path allowed |
| restart_autoneg | output | 1 | One-cycle restart request to auto-negotiation |

## Verification
Two things can fall in the same cycle: the millisecond tick that would expire the loss count, and a link pulse or receive event that restarts it. The bench lets the link go LOSS_MS-1 idle ticks after bring-up. It then presents the final tick together with receive activity, and expects link_good to stay high. After that it expects exactly LOSS_MS further idle ticks before the link drops. The same sweep is repeated with a link pulse in place of receive activity. It is repeated again with auto-negotiation disabled, which must keep the restart request silent.

// File: rtl/lim_pkg.sv
// Package: shared types for the link integrity monitor.
// Assumes: nothing beyond IEEE 1800-2017.
package lim_pkg;

    // Link state held by the integrity state machine.
    typedef enum logic [0:0] {
        LINK_DOWN = 1'b0,
        LINK_UP   = 1'b1
    } link_state_e;

endpackage

// File: rtl/lim_pulse_gen.sv
// Module: lim_pulse_gen
// Emits a one-cycle link-pulse strobe every PERIOD_MS millisecond ticks
// while the port is in 10BASE-T mode. Independent of link state.
// Assumes: ms_tick is a single-cycle strobe; PERIOD_MS >= 1.
module lim_pulse_gen #(
    parameter int PERIOD_MS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_10bt,
    input  logic ms_tick,
    output logic pulse_out
);

    localparam int PER_EFF = (PERIOD_MS < 1) ? 1 : PERIOD_MS;
    localparam int CNT_W   = (PER_EFF < 2) ? 1 : $clog2(PER_EFF);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PER_EFF - 1);

    logic [CNT_W-1:0] tick_cnt;
    logic             pulse_q;
    logic             wrap;

    // Last tick of a period reached on this tick.
    always_comb begin
        wrap = ms_tick && (tick_cnt == LAST);
    end

    // Tick counter: cleared outside 10BASE-T mode, wraps each period.
    always_ff @(posedge clk) begin
        if (!rst_n || !mode_10bt) begin
            tick_cnt <= '0;
        end else if (ms_tick) begin
            tick_cnt <= wrap ? '0 : tick_cnt + 1'b1;
        end
    end

    // Registered strobe, one cycle after the period-closing tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !mode_10bt) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= wrap;
        end
    end

    assign pulse_out = pulse_q;

    // R9: no pulse appears one cycle after the mode was off.
    a_r9_silent_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_10bt |=> !pulse_out);

    // R8: every strobe follows a tick taken in 10BASE-T mode.
    a_r8_pulse_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |-> ($past(ms_tick) && $past(mode_10bt)));

    generate
        if (PER_EFF > 1) begin : g_spacing
            // R8: strobes are isolated single cycles when the period exceeds one tick.
            a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
                pulse_out |=> !pulse_out);
        end
    endgenerate

endmodule

// File: rtl/lim_loss_timer.sv
// Module: lim_loss_timer
// Counts millisecond ticks since the last link pulse or receive event
// while the link is up, and flags the cycle in which the timeout expires.
// Assumes: run is the registered link state; an event in the same cycle
// as the expiring tick takes priority and restarts the count.
module lim_loss_timer #(
    parameter int LOSS_MS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic activity,
    input  logic ms_tick,
    output logic expire
);

    localparam int LOSS_EFF = (LOSS_MS < 1) ? 1 : LOSS_MS;
    localparam int CNT_W    = (LOSS_EFF < 2) ? 1 : $clog2(LOSS_EFF);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LOSS_EFF - 1);

    logic [CNT_W-1:0] idle_cnt;

    // Expiry: last idle tick reached with no fresh activity this cycle.
    always_comb begin
        expire = run && !activity && ms_tick && (idle_cnt == LAST);
    end

    // Idle counter: held at zero when down, cleared by activity, bumped per tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || activity) begin
            idle_cnt <= '0;
        end else if (ms_tick) begin
            idle_cnt <= (idle_cnt == LAST) ? '0 : idle_cnt + 1'b1;
        end
    end

    // R4: the idle count never passes the timeout.
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cnt <= LAST);

    // R5: activity in a cycle leaves a zero count behind it.
    a_r5_activity_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (run && activity) |=> (idle_cnt == '0));

endmodule

// File: rtl/lim_link_fsm.sv
// Module: lim_link_fsm
// Holds the link-good state and produces the restart request to
// auto-negotiation on link loss.
// Assumes: link_pulse_in is already qualified; expire comes from the loss
// timer and is only raised while the link is up.
module lim_link_fsm
    import lim_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_10bt,
    input  logic an_enable,
    input  logic link_pulse_in,
    input  logic expire,
    output logic link_up,
    output logic restart_req
);

    link_state_e state_q;
    link_state_e state_d;
    logic        restart_q;

    // Next state: pulses bring the link up, expiry or mode exit take it down.
    always_comb begin
        state_d = state_q;
        if (!mode_10bt) begin
            state_d = LINK_DOWN;
        end else begin
            case (state_q)
                LINK_DOWN: if (link_pulse_in) state_d = LINK_UP;
                LINK_UP:   if (expire)        state_d = LINK_DOWN;
                default:                      state_d = LINK_DOWN;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LINK_DOWN;
        end else begin
            state_q <= state_d;
        end
    end

    // Restart request: one cycle, only on a timed-out loss with AN enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restart_q <= 1'b0;
        end else begin
            restart_q <= mode_10bt && expire && an_enable && (state_q == LINK_UP);
        end
    end

    assign link_up     = (state_q == LINK_UP);
    assign restart_req = restart_q;

    // R6: a restart request marks the first cycle after the link fell.
    a_r6_restart_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |-> (!link_up && $past(link_up)));

    // R6: no restart request unless auto-negotiation was enabled.
    a_r6_needs_an: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |-> $past(an_enable));

    // R2: the link only comes up after a received link pulse in 10BASE-T mode.
    a_r2_rise_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |-> ($past(link_pulse_in) && $past(mode_10bt)));

    // R10: leaving 10BASE-T mode drops the link.
    a_r10_mode_off_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_10bt |=> !link_up);

    // R10: mode exit never raises a restart request.
    a_r10_no_restart_off: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_10bt |=> !restart_req);

endmodule

// File: rtl/link_integrity_mon.sv
// Module: link_integrity_mon (top)
// 10BASE-T link integrity monitor: link-good tracking from received link
// pulses and receive activity, transmit gating with a test-bypass bit,
// restart request to auto-negotiation, and periodic link-pulse emission.
// Assumes: all inputs are synchronous to clk; ms_tick is a one-cycle strobe.
module link_integrity_mon #(
    parameter int LOSS_MS         = 100,
    parameter int PULSE_PERIOD_MS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic mode_10bt,
    input  logic an_enable,
    input  logic test_bypass,
    input  logic link_pulse_in,
    input  logic rx_active,
    output logic link_pulse_out,
    output logic link_good,
    output logic tx_enable,
    output logic restart_autoneg
);

    logic link_up;
    logic expire;
    logic activity;

    // Any sign of life from the far end.
    always_comb begin
        activity = link_pulse_in || rx_active;
    end

    lim_pulse_gen #(
        .PERIOD_MS (PULSE_PERIOD_MS)
    ) u_pulse_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_10bt (mode_10bt),
        .ms_tick   (ms_tick),
        .pulse_out (link_pulse_out)
    );

    lim_loss_timer #(
        .LOSS_MS (LOSS_MS)
    ) u_loss_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (link_up),
        .activity (activity),
        .ms_tick  (ms_tick),
        .expire   (expire)
    );

    lim_link_fsm u_link_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_10bt     (mode_10bt),
        .an_enable     (an_enable),
        .link_pulse_in (link_pulse_in),
        .expire        (expire),
        .link_up       (link_up),
        .restart_req   (restart_autoneg)
    );

    // Transmit gate: link good or integrity test bypassed.
    always_comb begin
        link_good = link_up;
        tx_enable = link_up || test_bypass;
    end

    // R4: the link only drops on a tick without activity, or on mode exit.
    a_r4_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_good) |-> (!$past(mode_10bt) ||
                              ($past(ms_tick) && !$past(link_pulse_in) && !$past(rx_active))));

    // R5: activity while up keeps the link up in the next cycle.
    a_r5_activity_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (link_good && mode_10bt && (link_pulse_in || rx_active)) |=> link_good);

endmodule

// File: tb/link_integrity_mon_tb.sv
module link_integrity_mon_tb;

    localparam int LOSS = 4;
    localparam int PER  = 3;

    logic clk = 1'b0;
    logic rst_n, ms_tick, mode_10bt, an_enable, test_bypass, link_pulse_in, rx_active;
    logic link_pulse_out, link_good, tx_enable, restart_autoneg;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    always #2 clk = ~clk;

    link_integrity_mon #(.LOSS_MS(LOSS), .PULSE_PERIOD_MS(PER)) u_dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .mode_10bt(mode_10bt),
        .an_enable(an_enable), .test_bypass(test_bypass),
        .link_pulse_in(link_pulse_in), .rx_active(rx_active),
        .link_pulse_out(link_pulse_out), .link_good(link_good),
        .tx_enable(tx_enable), .restart_autoneg(restart_autoneg));

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // One clock: drive inputs just after an edge, sample just after the next.
    task automatic cyc(input logic lp, input logic rx, input logic tk);
        link_pulse_in = lp; rx_active = rx; ms_tick = tk;
        @(posedge clk); #1;
        link_pulse_in = 1'b0; rx_active = 1'b0; ms_tick = 1'b0;
    endtask

    task automatic bring_up();
        cyc(1'b1, 1'b0, 1'b0);
        chk("R2", "link_good after pulse", link_good, 1'b1);
    endtask

    task automatic watchdog();
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        fork watchdog(); join_none
        rst_n = 1'b0; ms_tick = 0; mode_10bt = 1; an_enable = 1; test_bypass = 0;
        link_pulse_in = 0; rx_active = 0;
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        chk("R1", "link_good", link_good, 1'b0);
        chk("R1", "tx_enable", tx_enable, 1'b0);
        chk("R1", "restart", restart_autoneg, 1'b0);
        chk("R1", "pulse_out", link_pulse_out, 1'b0);

        // R8: emission sweep from a fresh count
        for (int k = 1; k <= 3*PER + 1; k++) begin
            cyc(0, 0, 1);
            chk("R8", "pulse after tick", link_pulse_out, (k % PER) == 0);
            cyc(0, 0, 0);
            chk("R8", "pulse idle", link_pulse_out, 1'b0);
        end

        // R3: receive activity alone keeps the link down
        cyc(0, 1, 0);
        chk("R3", "link_good on rx only", link_good, 1'b0);
        chk("R7", "tx_enable down", tx_enable, 1'b0);

        // R4/R6: loss sweep with auto-negotiation enabled
        bring_up();
        chk("R7", "tx_enable up", tx_enable, 1'b1);
        for (int k = 1; k <= LOSS + 2; k++) begin
            cyc(0, 0, 1);
            chk("R4", "link_good idle ticks", link_good, k < LOSS);
            chk("R6", "restart on loss", restart_autoneg, k == LOSS);
        end

        // R4: pulse and rx each restart the loss count
        for (int v = 0; v < 2; v++) begin
            bring_up();
            for (int k = 1; k < LOSS; k++) cyc(0, 0, 1);
            cyc(v == 0, v == 1, 0);
            for (int k = 1; k <= LOSS; k++) begin
                cyc(0, 0, 1);
                chk("R4", "restart of count", link_good, k < LOSS);
            end
        end

        // R5: activity coinciding with the expiring tick
        for (int v = 0; v < 2; v++) begin
            bring_up();
            for (int k = 1; k < LOSS; k++) cyc(0, 0, 1);
            cyc(v == 0, v == 1, 1);
            chk("R5", "held on coincident event", link_good, 1'b1);
            chk("R5", "no restart on coincident event", restart_autoneg, 1'b0);
            for (int k = 1; k <= LOSS; k++) begin
                cyc(0, 0, 1);
                chk("R5", "fresh count after coincidence", link_good, k < LOSS);
            end
            cyc(0, 0, 0);
            chk("R6", "restart one cycle", restart_autoneg, 1'b0);
        end

        // R6: auto-negotiation disabled suppresses the request
        an_enable = 1'b0;
        bring_up();
        for (int k = 1; k <= LOSS + 1; k++) begin
            cyc(0, 0, 1);
            chk("R6", "no restart with AN off", restart_autoneg, 1'b0);
        end
        an_enable = 1'b1;

        // R7: bypass forces transmit with the link down
        test_bypass = 1'b1;
        cyc(0, 0, 0);
        chk("R7", "tx_enable bypass", tx_enable, 1'b1);
        chk("R7", "link_good bypass", link_good, 1'b0);

        // R10: mode exit drops the link without a request; pulses ignored
        bring_up();
        mode_10bt = 1'b0;
        cyc(0, 0, 0);
        chk("R10", "link_good mode off", link_good, 1'b0);
        chk("R10", "restart mode off", restart_autoneg, 1'b0);
        cyc(1, 0, 0);
        chk("R10", "pulse ignored mode off", link_good, 1'b0);
        // R9: no emission while mode is off
        for (int k = 1; k <= PER + 1; k++) begin
            cyc(0, 0, 1);
            chk("R9", "no pulse mode off", link_pulse_out, 1'b0);
        end

        // R9: emission resumes from zero, independent of link and bypass
        mode_10bt = 1'b1;
        an_enable = 1'b0;
        bring_up();
        for (int k = 1; k <= 2*PER; k++) begin
            cyc(0, 0, 1);
            chk("R9", "pulse with bypass/link", link_pulse_out, (k % PER) == 0);
        end
        test_bypass = 1'b0;
        cyc(0, 0, 0);
        chk("R7", "tx_enable tracks link", tx_enable, link_good);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule